// File: doc/BRIEF.md
# Complex Multiplier with Concurrent Error Detection

This block multiplies two signed fixed-point complex numbers, (a + jb) and (c + jd). The main datapath needs only three multipliers. It forms t1 = (a+b)(c+d), t2 = a·c and t3 = b·d. The real result is t2 − t3 and the imaginary result is t1 − t2 − t3. Every subtractor takes its left operand minus its right operand.

A shadow checker runs beside the main path on every item. It uses three more multipliers and makes two equality tests:

- **Sum check.** The sum of the two outputs is compared with a(c+d) + b(c−d), which the checker builds on its own.
- **Product check.** A second copy of a·c is compared with t2. This test is needed because a wrong t2 shifts the real and imaginary outputs by equal and opposite amounts, so their sum does not change.

Any mismatch raises an error flag. The flag leaves the block in the same cycle as the result it belongs to.

Internal widths are sized so that nothing overflows. With W-bit operands, the pre-adders are W+1 bits and the products and outputs are 2W+2 bits. A build option lets the checker's adders work on fewer low-order bits. A verification-only input can XOR a fixed mask onto any one of the three main products, to show that each single-product fault is caught.

Top module: `cmul_ced`

## Requirements
- R1: When `prod_valid` is high for an item with no injected fault, `prod_re` equals ac − bd, exact in 2W+2 bits.
- R2: When `prod_valid` is high for an item with no injected fault, `prod_im` equals ad + bc, exact in 2W+2 bits.
- R3: Each item sampled with `in_valid` high appears with `prod_valid` high exactly 3 clock edges later. The block accepts a new item on every cycle, with or without gaps between items.
- R4: While `rst_n` is low, and after release until the first accepted item reaches the output, `prod_valid` and `ced_err` are low.
- R5: In full-precision mode (`CHK_DROP` = 0), a fault-free item never raises `ced_err`. This holds for every operand value, including the most negative one, −2^(W−1).
- R6: An item accepted with `inj_site` = 2'b01 has the mask XORed onto t1, and its output cycle shows `ced_err` high.
- R7: An item accepted with `inj_site` = 2'b10 has the mask XORed onto the shared product t2, and its output cycle shows `ced_err` high.
- R8: An item accepted with `inj_site` = 2'b11 has the mask XORed onto t3, and its output cycle shows `ced_err` high.
- R9: `ced_err` is high only together with `prod_valid`, and applies only to its own item. A clean item that follows a faulty one shows `ced_err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| op1_re | input | W | a, real part of the first operand (signed) |
| op1_im | input | W | b, imaginary part of the first operand (signed) |
| op2_re | input | W | c, real part of the second operand (signed) |
| op2_im | input | W | d, imaginary part of the second operand (signed) |
| inj_site | input | 2 | Fault injection select, sampled with `in_valid`: 00 none, 01 t1, 10 t2, 11 t3 |
| prod_re | output | 2W+2 | Real part of the product (signed) |
| prod_im | output | 2W+2 | Imaginary part of the product (signed) |
| prod_valid | output | 1 | Result valid |
| ced_err | output | 1 | Error detected for this result |

## Verification
Some properties are checked by assertions on every cycle:

- the three-edge latency;
- the exact real and imaginary values, checked against the operands from three edges earlier;
- the error flag never rising without a valid result;
- the absence of false alarms on clean items;
- the flag rising on every injected item.

The scoreboard bench covers what only chosen stimulus can show:

- the extreme operand corners, where the most negative values push the products to their largest magnitude;
- a t2 fault, which the sum check alone would miss;
- the flag clearing on the clean item right after a faulty one;
- back-to-back traffic mixed with gaps.

// File: rtl/cmul_ced_pkg.sv
package cmul_ced_pkg;

   // Which main-path product receives the injected fault mask.
   typedef enum logic [1:0] {
      INJ_NONE = 2'd0,
      INJ_T1   = 2'd1,
      INJ_T2   = 2'd2,
      INJ_T3   = 2'd3
   } inj_site_e;

   // Product width needed to hold (W+1)x(W+1) signed products without overflow.
   function automatic int prod_width(input int w);
      return 2 * w + 2;
   endfunction

endpackage

// File: rtl/cmul_main_path.sv
// Three-multiplier main datapath: pre-adders and products (combinational).
module cmul_main_path
   import cmul_ced_pkg::*;
#(
   parameter int          W    = 12,
   parameter int          MW   = 2 * W + 2,
   parameter logic [MW-1:0] MASK = '0
) (
   input  logic signed [W-1:0]  a,
   input  logic signed [W-1:0]  b,
   input  logic signed [W-1:0]  c,
   input  logic signed [W-1:0]  d,
   input  inj_site_e            inj,
   output logic signed [MW-1:0] t1,
   output logic signed [MW-1:0] t2,
   output logic signed [MW-1:0] t3
);
   localparam int PW = W + 1;

   logic signed [PW-1:0] sum_ab, sum_cd;
   logic signed [MW-1:0] raw [3];
   logic [MW-1:0]        flip [3];

   assign sum_ab = PW'(a) + PW'(b);
   assign sum_cd = PW'(c) + PW'(d);

   assign raw[0] = MW'(sum_ab) * MW'(sum_cd);
   assign raw[1] = MW'(a) * MW'(c);
   assign raw[2] = MW'(b) * MW'(d);

   // One fault-mask gate per product; site index k+1 selects product k.
   for (genvar k = 0; k < 3; k++) begin : g_inj
      assign flip[k] = (inj == inj_site_e'(k + 1)) ? MASK : '0;
   end

   assign t1 = raw[0] ^ flip[0];
   assign t2 = raw[1] ^ flip[1];
   assign t3 = raw[2] ^ flip[2];

endmodule

// File: rtl/cmul_shadow.sv
// Redundant checker products: a(c+d), b(c-d) and a second copy of a*c.
module cmul_shadow #(
   parameter int W  = 12,
   parameter int MW = 2 * W + 2
) (
   input  logic signed [W-1:0]  a,
   input  logic signed [W-1:0]  b,
   input  logic signed [W-1:0]  c,
   input  logic signed [W-1:0]  d,
   output logic signed [MW-1:0] p_a,
   output logic signed [MW-1:0] p_b,
   output logic signed [MW-1:0] p_ac
);
   localparam int PW = W + 1;

   logic signed [PW-1:0] c_plus_d, c_minus_d;

   // Own pre-adders: shares nothing with the main path.
   assign c_plus_d  = PW'(c) + PW'(d);
   assign c_minus_d = PW'(c) - PW'(d);

   assign p_a  = MW'(a) * MW'(c_plus_d);
   assign p_b  = MW'(b) * MW'(c_minus_d);
   assign p_ac = MW'(a) * MW'(c);

endmodule

// File: rtl/cmul_combine.sv
// Output subtractors plus the two comparisons; DROP > 0 selects reduced-precision checks.
module cmul_combine #(
   parameter int MW   = 26,
   parameter int DROP = 0
) (
   input  logic signed [MW-1:0] t1,
   input  logic signed [MW-1:0] t2,
   input  logic signed [MW-1:0] t3,
   input  logic signed [MW-1:0] p_a,
   input  logic signed [MW-1:0] p_b,
   input  logic signed [MW-1:0] p_ac,
   output logic signed [MW-1:0] y_re,
   output logic signed [MW-1:0] y_im,
   output logic                 bad_sum,
   output logic                 bad_ac
);
   localparam int SW = MW + 1;

   logic signed [MW-1:0] t1_minus_t2;
   logic signed [SW-1:0] out_sum;

   assign y_re        = t2 - t3;
   assign t1_minus_t2 = t1 - t2;
   assign y_im        = t1_minus_t2 - t3;
   assign out_sum     = SW'(y_re) + SW'(y_im);

   if (DROP == 0) begin : g_full
      logic signed [SW-1:0] ref_sum;
      assign ref_sum = SW'(p_a) + SW'(p_b);
      assign bad_sum = (out_sum != ref_sum);
      assign bad_ac  = (t2 != p_ac);
   end else begin : g_reduced
      // The checker adder sees only the upper bits of each term. The sum of the
      // floors lies 0 or 1 below the floor of the sum, so both are accepted.
      logic signed [SW-1:0] hi_a, hi_b, hi_out, gap;
      assign hi_a    = SW'(p_a) >>> DROP;
      assign hi_b    = SW'(p_b) >>> DROP;
      assign hi_out  = out_sum >>> DROP;
      assign gap     = hi_out - (hi_a + hi_b);
      assign bad_sum = (gap != SW'(0)) && (gap != SW'(1));
      assign bad_ac  = ((t2 >>> DROP) != (p_ac >>> DROP));
   end

endmodule

// File: rtl/cmul_ced.sv
// Pipelined complex multiplier with concurrent error detection.
// Stage 1: operand registers. Stage 2: product registers. Stage 3: results and flag.
module cmul_ced
   import cmul_ced_pkg::*;
#(
   parameter int              W        = 12,
   parameter int              CHK_DROP = 0,
   parameter longint unsigned INJ_MASK = 64'h100
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic signed [W-1:0]           op1_re,
   input  logic signed [W-1:0]           op1_im,
   input  logic signed [W-1:0]           op2_re,
   input  logic signed [W-1:0]           op2_im,
   input  logic [1:0]                    inj_site,
   output logic signed [2*W+1:0]         prod_re,
   output logic signed [2*W+1:0]         prod_im,
   output logic                          prod_valid,
   output logic                          ced_err
);
   localparam int            MW     = prod_width(W);
   localparam logic [MW-1:0] MASK_V = MW'(INJ_MASK);

   // Parameter checks at elaboration.
   if (W < 2 || W > 30) begin : g_bad_width
      $error("cmul_ced: W must lie in 2..30");
   end
   if (CHK_DROP < 0 || CHK_DROP > MW - 2) begin : g_bad_drop
      $error("cmul_ced: CHK_DROP out of range");
   end
   if (MASK_V == '0) begin : g_bad_mask
      $error("cmul_ced: INJ_MASK has no bit inside the product width");
   end

   // Stage 1
   logic signed [W-1:0] a_s1, b_s1, c_s1, d_s1;
   inj_site_e           inj_s1;
   logic                v_s1;

   // Stage 2
   logic signed [MW-1:0] t1_s2, t2_s2, t3_s2, pa_s2, pb_s2, pac_s2;
   inj_site_e            inj_s2;
   logic                 v_s2;

   // Stage 3 tag (used by the checks below)
   inj_site_e            inj_s3;

   logic signed [MW-1:0] t1_c, t2_c, t3_c, pa_c, pb_c, pac_c;
   logic signed [MW-1:0] yre_c, yim_c;
   logic                 bad_sum_c, bad_ac_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_s1       <= 1'b0;
         v_s2       <= 1'b0;
         prod_valid <= 1'b0;
         ced_err    <= 1'b0;
      end else begin
         v_s1       <= in_valid;
         v_s2       <= v_s1;
         prod_valid <= v_s2;
         ced_err    <= v_s2 & (bad_sum_c | bad_ac_c);
      end
   end

   always_ff @(posedge clk) begin
      a_s1   <= op1_re;
      b_s1   <= op1_im;
      c_s1   <= op2_re;
      d_s1   <= op2_im;
      inj_s1 <= in_valid ? inj_site_e'(inj_site) : INJ_NONE;
      t1_s2  <= t1_c;
      t2_s2  <= t2_c;
      t3_s2  <= t3_c;
      pa_s2  <= pa_c;
      pb_s2  <= pb_c;
      pac_s2 <= pac_c;
      inj_s2 <= inj_s1;
      inj_s3 <= inj_s2;
      prod_re <= yre_c;
      prod_im <= yim_c;
   end

   cmul_main_path #(.W(W), .MW(MW), .MASK(MASK_V)) u_main (
      .a(a_s1), .b(b_s1), .c(c_s1), .d(d_s1), .inj(inj_s1),
      .t1(t1_c), .t2(t2_c), .t3(t3_c)
   );

   cmul_shadow #(.W(W), .MW(MW)) u_shadow (
      .a(a_s1), .b(b_s1), .c(c_s1), .d(d_s1),
      .p_a(pa_c), .p_b(pb_c), .p_ac(pac_c)
   );

   cmul_combine #(.MW(MW), .DROP(CHK_DROP)) u_comb (
      .t1(t1_s2), .t2(t2_s2), .t3(t3_s2),
      .p_a(pa_s2), .p_b(pb_s2), .p_ac(pac_s2),
      .y_re(yre_c), .y_im(yim_c),
      .bad_sum(bad_sum_c), .bad_ac(bad_ac_c)
   );

   // Edges seen since reset release, saturating at 3; lets $past look back safely.
   logic [1:0] edges_up;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                edges_up <= 2'd0;
      else if (edges_up != 2'd3) edges_up <= edges_up + 2'd1;
   end

   assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (edges_up == 2'd3) |-> (prod_valid == $past(in_valid, 3)));

   assert_real_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (edges_up == 2'd3 && prod_valid && inj_s3 == INJ_NONE) |->
      (prod_re == MW'($past(op1_re, 3)) * MW'($past(op2_re, 3))
                - MW'($past(op1_im, 3)) * MW'($past(op2_im, 3))));

   assert_imag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (edges_up == 2'd3 && prod_valid && inj_s3 == INJ_NONE) |->
      (prod_im == MW'($past(op1_re, 3)) * MW'($past(op2_im, 3))
                + MW'($past(op1_im, 3)) * MW'($past(op2_re, 3))));

   assert_err_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ced_err |-> prod_valid);

   assert_idle_after_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edges_up < 2'd3) |-> (!prod_valid && !ced_err));

   if (CHK_DROP == 0) begin : g_full_checks
      assert_no_false_alarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (prod_valid && inj_s3 == INJ_NONE) |-> !ced_err);

      // Any single-product fault is flagged (covers R6, R7, R8).
      assert_fault_caught_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (prod_valid && inj_s3 != INJ_NONE) |-> ced_err);
   end

endmodule

// File: tb/cmul_ced_test.sv
`timescale 1ns/1ps
module cmul_ced_test;
   localparam int W  = 12;
   localparam int MW = 2 * W + 2;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 in_valid = 1'b0;
   logic signed [W-1:0]  op1_re = '0, op1_im = '0, op2_re = '0, op2_im = '0;
   logic [1:0]           inj_site = 2'b00;
   logic signed [MW-1:0] prod_re, prod_im;
   logic                 prod_valid, ced_err;

   cmul_ced #(.W(W)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op1_re(op1_re), .op1_im(op1_im), .op2_re(op2_re), .op2_im(op2_im),
      .inj_site(inj_site),
      .prod_re(prod_re), .prod_im(prod_im),
      .prod_valid(prod_valid), .ced_err(ced_err)
   );

   always #4 clk = ~clk;   // 125 MHz

   typedef struct {
      longint     re;
      longint     im;
      longint     due;
      logic [1:0] site;
   } item_t;

   item_t  sb[$];
   int     checks = 0;
   int     errors = 0;
   longint edges = 0;
   bit     done = 1'b0;

   always @(posedge clk) edges++;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // Driver: applies one item and pushes its expected result into the scoreboard.
   task automatic send(input logic signed [W-1:0] a, input logic signed [W-1:0] b,
                       input logic signed [W-1:0] c, input logic signed [W-1:0] d,
                       input logic [1:0] site);
      item_t it;
      @(negedge clk);
      op1_re = a; op1_im = b; op2_re = c; op2_im = d;
      inj_site = site; in_valid = 1'b1;
      it.re   = longint'(a) * longint'(c) - longint'(b) * longint'(d);
      it.im   = longint'(a) * longint'(d) + longint'(b) * longint'(c);
      it.due  = edges + 3;
      it.site = site;
      sb.push_back(it);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         in_valid = 1'b0;
         inj_site = 2'b00;
      end
   endtask

   task automatic send_rand(input logic [1:0] site);
      send(W'($urandom()), W'($urandom()), W'($urandom()), W'($urandom()), site);
   endtask

   // Monitor: pops and compares each result as it appears.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (prod_valid) begin
            if (sb.size() == 0) begin
               check(1'b0, "R3 valid with no item pending", 1, 0);
            end else begin
               item_t it;
               it = sb.pop_front();
               check(edges == it.due, "R3 latency", edges, it.due);
               case (it.site)
                  2'b00: begin
                     check(longint'(prod_re) == it.re, "R1 real part", longint'(prod_re), it.re);
                     check(longint'(prod_im) == it.im, "R2 imag part", longint'(prod_im), it.im);
                     check(ced_err == 1'b0, "R5/R9 clean item flagged", ced_err, 0);
                  end
                  2'b01: check(ced_err == 1'b1, "R6 t1 fault missed", ced_err, 1);
                  2'b10: check(ced_err == 1'b1, "R7 t2 fault missed", ced_err, 1);
                  default: check(ced_err == 1'b1, "R8 t3 fault missed", ced_err, 1);
               endcase
            end
         end else begin
            check(ced_err == 1'b0, "R9 flag without valid", ced_err, 0);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R4: outputs quiet during and after reset until the first item arrives.
      repeat (3) begin
         @(negedge clk);
         check(!prod_valid && !ced_err, "R4 during reset", {prod_valid, ced_err}, 0);
      end
      rst_n = 1'b1;
      repeat (4) begin
         @(negedge clk);
         check(!prod_valid && !ced_err, "R4 after release", {prod_valid, ced_err}, 0);
      end

      // R5: extreme corners, back to back (R3 throughput).
      send(-12'sd2048, -12'sd2048, -12'sd2048, -12'sd2048, 2'b00);
      send( 12'sd2047,  12'sd2047,  12'sd2047,  12'sd2047, 2'b00);
      send(-12'sd2048,  12'sd2047,  12'sd2047, -12'sd2048, 2'b00);
      send( 12'sd2047, -12'sd2048, -12'sd2048,  12'sd2047, 2'b00);
      send( 12'sd0,     12'sd0,     12'sd0,     12'sd0,    2'b00);
      send(-12'sd1,     12'sd1,    -12'sd1,     12'sd1,    2'b00);
      idle(2);

      // R7: t2 fault with a*c = 0, then a clean item right after (R9).
      send(12'sd0, 12'sd5, 12'sd7, 12'sd3, 2'b10);
      send(12'sd0, 12'sd5, 12'sd7, 12'sd3, 2'b00);
      // R6, R8 on corner operands, each followed by a clean item.
      send(-12'sd2048, -12'sd2048, -12'sd2048, -12'sd2048, 2'b01);
      send(-12'sd2048, -12'sd2048, -12'sd2048, -12'sd2048, 2'b00);
      send( 12'sd2047,  12'sd2047,  12'sd2047,  12'sd2047, 2'b11);
      send( 12'sd2047,  12'sd2047,  12'sd2047,  12'sd2047, 2'b00);
      idle(1);

      // Random traffic with gaps and scattered faults on every site.
      for (int i = 0; i < 400; i++) begin
         logic [1:0] s;
         s = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
         send_rand(s);
         if ($urandom_range(0, 5) == 0) idle($urandom_range(1, 3));
      end
      for (int k = 1; k <= 3; k++) begin
         send_rand(2'(k));
         send_rand(2'b00);
      end

      idle(6);
      check(sb.size() == 0, "R3 items left undelivered", sb.size(), 0);
      finish_run();
   end

endmodule